// File: doc/BRIEF.md
# Sensor Trim Calibration Converter

This block maps between degrees Celsius and the raw reading code of an on-chip temperature sensor. The mapping is corrected by two factory trim points. A load strobe captures a trim word, checks the two trim points it holds, and swaps any implausible point for a fallback value. These values come from configuration inputs, so the conversion never runs on a blank or corrupt trim.

After a load, the block takes single requests over a valid/ready handshake. Each request converts in one direction: a temperature to a code, or a code to a temperature. It uses one of three calibration schemes:

- a fixed offset,
- a single trim point, or
- a straight line through both trim points.

The straight-line scheme needs a division, which runs on a bit-serial divider. The other two finish in one cycle. Every response carries an error flag for an out-of-range result, a zero divisor, or a conversion asked for before any trim was loaded.

The controller has three states:

- `ST_IDLE` accepts a request.
- `ST_DIVIDE` waits for the divider.
- `ST_DONE` presents the response for one cycle.

There are four transitions:

- IDLE→DIVIDE when a valid two-point request has a non-zero divisor.
- IDLE→DONE for every other accepted request.
- DIVIDE→DONE when the divider finishes.
- DONE→IDLE always.

Top module: `thermcal_conv`

## Requirements
- R1: On a cycle with `trim_load` high, trim point E1 is taken from `trim_word[7:0]` and E2 from `trim_word[15:8]` (after R2/R3 substitution). The values are held until the next load.
- R2: E1 is replaced by `fallback_word[7:0]` when its raw value is 0, less than `trim_min`, or greater than `trim_max`.
- R3: E2 is replaced by `fallback_word[15:8]` only when its raw value is 0.
- R4: `cal_mode` 2'b00 (and 2'b11) selects fixed offset. With `req_dir`=0 (temperature to code) the result is value + `fixed_offset`. With `req_dir`=1 (code to temperature) it is value − `fixed_offset`.
- R5: `cal_mode` 2'b01 selects one-point calibration. Forward is T + E1 − P1 and inverse is code − E1 + P1, where P1 = `ref_lo`.
- R6: `cal_mode` 2'b10 with `req_dir`=0 gives (T − P1)·(E2 − E1)/(P2 − P1) + E1, where P2 = `ref_hi`. The quotient is truncated toward zero.
- R7: `cal_mode` 2'b10 with `req_dir`=1 gives (code − E1)·(P2 − P1)/(E2 − E1) + P1. The quotient is truncated toward zero.
- R8: A result below 0 or above 255 gives `rsp_err`=1 and `rsp_value`=0.
- R9: In two-point mode a zero divisor gives `rsp_err`=1 and `rsp_value`=0. The zero divisor is P2 = P1 forward and E2 = E1 inverse.
- R10: Every request accepted before the first trim load returns `rsp_err`=1.
- R11: `req_ready` is high only when idle. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low until its response. `rsp_valid` is a one-cycle pulse. Offset and one-point responses appear in the cycle right after acceptance.
- R12: After reset, `req_ready`=1 and `rsp_valid`, `rsp_err` and `rsp_value` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trim_load | input | 1 | Strobe that captures and checks the trim word |
| trim_word | input | 32 | Raw trim word, E1 in [7:0], E2 in [15:8] |
| fallback_word | input | 32 | Substitute trim values in the same byte positions |
| trim_min | input | 8 | Lowest acceptable raw E1 |
| trim_max | input | 8 | Highest acceptable raw E1 |
| cal_mode | input | 2 | Calibration scheme select |
| ref_lo | input | 8 | First reference temperature P1 |
| ref_hi | input | 8 | Second reference temperature P2 |
| fixed_offset | input | 8 | Offset for fixed-offset mode |
| req_valid | input | 1 | Request present |
| req_dir | input | 1 | 0 = temperature to code, 1 = code to temperature |
| req_value | input | 8 | Value to convert |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_value | output | 8 | Converted value |
| rsp_err | output | 1 | Conversion failed |

## Verification
On every cycle, the bound checker enforces the handshake shape:

- acceptance drops `req_ready`;
- `rsp_valid` lasts one cycle and is followed by a return to idle;
- single-cycle modes answer in the next cycle;
- an error response always carries a zero value;
- responses before any trim load are errors.

The arithmetic is shown only by the bench scenarios, which a bench model checks. These cover:

- fallback substitution for each bad-trim condition;
- signed truncation of negative quotients;
- zero divisors in both directions;
- overflow at both ends of the range;
- a long random mix of modes, directions and trim reloads.

// File: rtl/thermcal_pkg.sv
package thermcal_pkg;
    typedef enum logic [1:0] {
        CAL_OFFSET = 2'b00,
        CAL_ONE    = 2'b01,
        CAL_TWO    = 2'b10,
        CAL_RSVD   = 2'b11
    } cal_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_DIVIDE = 2'b01,
        ST_DONE   = 2'b10
    } conv_state_e;
endpackage

// File: rtl/thermcal_trim.sv
module thermcal_trim #(
    parameter int W      = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] raw_word,
    input  logic [WORD_W-1:0] alt_word,
    input  logic [W-1:0]      lo_limit,
    input  logic [W-1:0]      hi_limit,
    output logic [W-1:0]      pt1,
    output logic [W-1:0]      pt2,
    output logic              have_trim
);
    logic [W-1:0] raw1, raw2, pick1, pick2;
    logic         bad1;
    logic         unused_bits;

    assign unused_bits = ^{raw_word[WORD_W-1:2*W], alt_word[WORD_W-1:2*W]};

    always_comb begin
        raw1  = raw_word[W-1:0];
        raw2  = raw_word[2*W-1:W];
        bad1  = (raw1 == '0) || (raw1 < lo_limit) || (raw1 > hi_limit);
        pick1 = bad1 ? alt_word[W-1:0] : raw1;
        pick2 = (raw2 == '0) ? alt_word[2*W-1:W] : raw2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt1       <= '0;
            pt2       <= '0;
            have_trim <= 1'b0;
        end else if (load) begin
            pt1       <= pick1;
            pt2       <= pick2;
            have_trim <= 1'b1;
        end
    end
endmodule

// File: rtl/thermcal_div.sv
module thermcal_div #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quot_q;
    logic [DEN_W-1:0] rem_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q;
    logic [DEN_W:0]   shifted, trial;
    logic             fits;

    always_comb begin
        shifted = {rem_q, quot_q[NUM_W-1]};
        trial   = shifted - {1'b0, den_q};
        fits    = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            quot_q <= num;
            rem_q  <= '0;
            den_q  <= den;
            cnt_q  <= CNT_W'(NUM_W);
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (run_q) begin
            rem_q  <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
            quot_q <= {quot_q[NUM_W-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
            run_q  <= (cnt_q != CNT_W'(1));
            done_q <= (cnt_q == CNT_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign quot = quot_q;
endmodule

// File: rtl/thermcal_conv.sv
module thermcal_conv
    import thermcal_pkg::*;
#(
    parameter int W      = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trim_load,
    input  logic [WORD_W-1:0] trim_word,
    input  logic [WORD_W-1:0] fallback_word,
    input  logic [W-1:0]      trim_min,
    input  logic [W-1:0]      trim_max,
    input  logic [1:0]        cal_mode,
    input  logic [W-1:0]      ref_lo,
    input  logic [W-1:0]      ref_hi,
    input  logic [W-1:0]      fixed_offset,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic [W-1:0]      req_value,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [W-1:0]      rsp_value,
    output logic              rsp_err
);
    localparam int DW    = W + 2;
    localparam int PW    = 2 * W + 2;
    localparam int NUM_W = 2 * W;
    localparam int SW    = 2 * W + 3;

    conv_state_e state_q, state_d;
    cal_mode_e   mode;
    logic [W-1:0] e1, e2, val_q, base_q;
    logic         loaded, err_q, neg_q, accept, div_start, div_done;
    logic [NUM_W-1:0] quot, num_mag;
    logic [W-1:0]     den_mag;

    logic signed [DW-1:0] sv, se1, se2, sp1, sp2, soff, direct, fa, fb, fden;
    logic [W-1:0]         fbase;
    logic signed [PW-1:0] prod;
    logic                 direct_bad, den_zero, neg_d;
    logic signed [SW-1:0] qext, qs, sum;
    logic                 fin_bad;

    thermcal_trim #(.W(W), .WORD_W(WORD_W)) u_trim (
        .clk(clk), .rst_n(rst_n), .load(trim_load),
        .raw_word(trim_word), .alt_word(fallback_word),
        .lo_limit(trim_min), .hi_limit(trim_max),
        .pt1(e1), .pt2(e2), .have_trim(loaded)
    );

    thermcal_div #(.NUM_W(NUM_W), .DEN_W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(num_mag), .den(den_mag), .done(div_done), .quot(quot)
    );

    // Operand selection and single-cycle arithmetic
    always_comb begin
        mode = cal_mode_e'(cal_mode);
        sv   = $signed({2'b00, req_value});
        se1  = $signed({2'b00, e1});
        se2  = $signed({2'b00, e2});
        sp1  = $signed({2'b00, ref_lo});
        sp2  = $signed({2'b00, ref_hi});
        soff = $signed({2'b00, fixed_offset});
        unique case (mode)
            CAL_ONE: direct = req_dir ? (sv - se1 + sp1) : (sv + se1 - sp1);
            default: direct = req_dir ? (sv - soff) : (sv + soff);
        endcase
        direct_bad = |direct[DW-1:W];
        if (req_dir) begin
            fa = sv - se1;  fb = sp2 - sp1; fden = se2 - se1; fbase = ref_lo;
        end else begin
            fa = sv - sp1;  fb = se2 - se1; fden = sp2 - sp1; fbase = e1;
        end
        prod     = PW'(fa) * PW'(fb);
        num_mag  = NUM_W'(prod[PW-1] ? -prod : prod);
        den_mag  = W'(fden[DW-1] ? -fden : fden);
        neg_d    = prod[PW-1] ^ fden[DW-1];
        den_zero = (fden == '0);
    end

    // Two-point completion: sign restore, base add, range check
    always_comb begin
        qext    = $signed({{(SW-NUM_W){1'b0}}, quot});
        qs      = neg_q ? -qext : qext;
        sum     = qs + $signed({{(SW-W){1'b0}}, base_q});
        fin_bad = |sum[SW-1:W];
    end

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign div_start = accept && (mode == CAL_TWO) && loaded && !den_zero;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = div_start ? ST_DIVIDE : ST_DONE;
            ST_DIVIDE: if (div_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            err_q  <= 1'b0;
            neg_q  <= 1'b0;
            base_q <= '0;
        end else if (accept) begin
            neg_q  <= neg_d;
            base_q <= fbase;
            if (!loaded || (mode == CAL_TWO && den_zero)) begin
                err_q <= 1'b1;
                val_q <= '0;
            end else if (mode != CAL_TWO) begin
                err_q <= direct_bad;
                val_q <= direct_bad ? '0 : direct[W-1:0];
            end
        end else if (state_q == ST_DIVIDE && div_done) begin
            err_q <= fin_bad;
            val_q <= fin_bad ? '0 : sum[W-1:0];
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_DONE);
    assign rsp_value = val_q;
    assign rsp_err   = err_q;
endmodule

// File: rtl/thermcal_conv_chk.sv
module thermcal_conv_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         trim_load,
    input logic [1:0]   cal_mode,
    input logic         req_valid,
    input logic         req_ready,
    input logic         rsp_valid,
    input logic [W-1:0] rsp_value,
    input logic         rsp_err
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         seen_q <= 1'b0;
        else if (trim_load) seen_q <= 1'b1;
    end

    a_r11_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    a_r11_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cal_mode != 2'b10) |=> rsp_valid);

    a_r8_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_value == '0));

    a_r10_untrimmed: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !seen_q) |-> rsp_err);
endmodule

bind thermcal_conv thermcal_conv_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trim_load(trim_load), .cal_mode(cal_mode),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_value(rsp_value), .rsp_err(rsp_err)
);

// File: tb/thermcal_conv_test.sv
module thermcal_conv_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trim_load = 1'b0;
    logic [31:0] trim_word = '0, fallback_word = '0;
    logic [7:0]  trim_min = '0, trim_max = '0;
    logic [1:0]  cal_mode = '0;
    logic [7:0]  ref_lo = '0, ref_hi = '0, fixed_offset = '0;
    logic        req_valid = 1'b0, req_dir = 1'b0;
    logic [7:0]  req_value = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [7:0]  rsp_value;

    int checks = 0, errors = 0;
    int m_e1 = 0, m_e2 = 0;
    bit m_ld = 0, finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermcal_conv uut (
        .clk(clk), .rst_n(rst_n), .trim_load(trim_load), .trim_word(trim_word),
        .fallback_word(fallback_word), .trim_min(trim_min), .trim_max(trim_max),
        .cal_mode(cal_mode), .ref_lo(ref_lo), .ref_hi(ref_hi),
        .fixed_offset(fixed_offset), .req_valid(req_valid), .req_dir(req_dir),
        .req_value(req_value), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_value(rsp_value), .rsp_err(rsp_err)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pick_e1(int r, int f, int lo, int hi);
        return (r == 0 || r < lo || r > hi) ? f : r;
    endfunction

    function automatic void model(input int md, input int dr, input int v,
                                  output bit err, output int val);
        int r = 0;
        bit bad = 0;
        int p1 = ref_lo, p2 = ref_hi, off = fixed_offset;
        if (!m_ld) begin err = 1; val = 0; return; end
        case (md)
            1: r = dr ? v - m_e1 + p1 : v + m_e1 - p1;
            2: if (dr == 0) begin
                   if (p2 == p1) bad = 1;
                   else r = (v - p1) * (m_e2 - m_e1) / (p2 - p1) + m_e1;
               end else begin
                   if (m_e2 == m_e1) bad = 1;
                   else r = (v - m_e1) * (p2 - p1) / (m_e2 - m_e1) + p1;
               end
            default: r = dr ? v - off : v + off;
        endcase
        if (!bad && (r < 0 || r > 255)) bad = 1;
        err = bad;
        val = bad ? 0 : r;
    endfunction

    task automatic load_trim(int tw, int fb, int lo, int hi);
        @(negedge clk);
        trim_word = 32'(tw); fallback_word = 32'(fb);
        trim_min = 8'(lo); trim_max = 8'(hi); trim_load = 1'b1;
        @(negedge clk);
        trim_load = 1'b0;
        m_e1 = pick_e1(tw & 255, fb & 255, lo, hi);
        m_e2 = ((tw >> 8) & 255) == 0 ? (fb >> 8) & 255 : (tw >> 8) & 255;
        m_ld = 1;
    endtask

    task automatic run_req(int md, int dr, int v, string tag);
        bit e_err;
        int e_val, cyc;
        string t;
        @(negedge clk);
        cal_mode = 2'(md); req_dir = dr[0]; req_value = 8'(v); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
        model(md, dr, v, e_err, e_val);
        if (tag != "") t = tag;
        else if (e_err) t = "R8";
        else if (md == 2) t = dr ? "R7" : "R6";
        else if (md == 1) t = "R5";
        else t = "R4";
        if (md != 2) check(cyc == 0, "R11 latency", cyc, 0);
        check(rsp_valid == 1'b1, {t, " rsp_valid"}, int'(rsp_valid), 1);
        check(rsp_err == e_err, {t, " err"}, int'(rsp_err), int'(e_err));
        check(int'(rsp_value) == e_val, {t, " value"}, int'(rsp_value), e_val);
    endtask

    initial begin
        int seed;
        seed = $urandom(20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(req_ready == 1'b1, "R12 ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R12 rsp_valid", int'(rsp_valid), 0);
        check(rsp_err == 1'b0, "R12 err", int'(rsp_err), 0);
        check(rsp_value == 8'd0, "R12 value", int'(rsp_value), 0);
        // R10 before any load
        fixed_offset = 8'd5;
        run_req(0, 0, 20, "R10");
        run_req(2, 1, 90, "R10");
        // R1 good trim, observe E1 through one-point and E2 through two-point at T=P2
        ref_lo = 8'd25; ref_hi = 8'd85;
        load_trim(32'hFFFF_5A32, 32'h0000_7040, 10, 200);
        run_req(1, 0, 25, "R1");
        run_req(2, 0, 85, "R1");
        // R2 E1 zero, below min, above max
        load_trim(32'h0000_5A00, 32'h0000_7040, 10, 200);
        run_req(1, 0, 25, "R2");
        load_trim(32'h0000_5A05, 32'h0000_7040, 10, 200);
        run_req(1, 0, 25, "R2");
        load_trim(32'h0000_5AF0, 32'h0000_7040, 10, 200);
        run_req(1, 0, 25, "R2");
        // R3 E2 zero replaced, nonzero kept
        load_trim(32'h0000_0032, 32'h0000_7040, 10, 200);
        run_req(2, 0, 85, "R3");
        // R6 negative slope, truncation toward zero: E1=100, E2=50
        load_trim(32'h0000_3264, 32'h0, 10, 200);
        run_req(2, 0, 30, "R6");
        run_req(2, 1, 97, "R7");
        // R9 zero divisors
        ref_hi = 8'd25;
        run_req(2, 0, 40, "R9");
        load_trim(32'h0000_4040, 32'h0, 10, 200);
        ref_hi = 8'd85;
        run_req(2, 1, 70, "R9");
        // R8 overflow at both ends, R4 offset incl. reserved mode
        fixed_offset = 8'd10;
        run_req(0, 0, 250, "R8");
        run_req(3, 1, 5, "R8");
        run_req(3, 0, 100, "R4");
        run_req(0, 1, 100, "R4");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0)
                load_trim(int'($urandom()), int'($urandom_range(1, 65535)),
                          int'($urandom_range(0, 60)), int'($urandom_range(150, 255)));
            ref_lo = 8'($urandom_range(0, 60));
            ref_hi = ($urandom_range(0, 9) == 0) ? ref_lo : 8'($urandom_range(60, 120));
            fixed_offset = 8'($urandom_range(0, 80));
            run_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                    int'($urandom_range(0, 255)), "");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule